// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

This block is a single-port synchronous static RAM core with 32-bit words and four byte lanes. The rising clock edge registers the address, the control inputs and the write data. Reads return through an output register one cycle later. The core does not generate burst addresses. An external sequencer supplies the word address for each cycle and a flag that marks the cycle as valid and selected. A flag from the same sequencer also marks cycles that were started by the processor-side address strobe. Those cycles are always reads.

Two write controls decide which lanes are written. A global write enable writes all four lanes. A byte-write qualifier lets the per-lane enables select lanes one by one. The data output works like a tri-state port: it comes with a drive enable, and an asynchronous output enable gates that drive. A sleep input stops all access immediately. When sleep is released, a fixed wake-up count must run out before the core accepts another access.

Top module: `sram_pipe_core`

## Requirements
- R1: The array holds 2**ADDR_W words of 32 bits, selected by `addr_i` (ADDR_W = 16 gives the full 64K-word array). Every address from 0 to 2**ADDR_W-1 can be written and read back.
- R2: In an accepted cycle with `gw_ni` low and `proc_start_i` low, all four lanes of the addressed word are written from `wdata_i`, whatever `bwe_ni` and `be_ni` are.
- R3: In an accepted cycle with `gw_ni` high and `bwe_ni` low, each lane k whose `be_ni[k]` is low is written: lane 0 is bits 7:0, lane 1 is 15:8, lane 2 is 23:16 and lane 3 is 31:24. The other lanes keep their contents.
- R4: In an accepted cycle with `gw_ni` high, and either `bwe_ni` high or `be_ni` equal to 4'b1111, the cycle is a read and nothing is written.
- R5: In an accepted cycle with `proc_start_i` high, the cycle is a read and nothing is written, whatever the write enables are.
- R6: A read accepted at edge N puts the word on `dq_o` with `dq_en_o` high in the cycle after edge N+1, for that one cycle only. A write cycle never drives the output. A read issued right after a write to the same address returns the new data.
- R7: While `oe_ni` is high, `dq_en_o` is low and `dq_o` is zero. This takes effect at once, without waiting for a clock edge.
- R8: A cycle with `cyc_valid_i` low performs no access and leaves the output undriven two edges later.
- R9: While `sleep_i` is high, no cycle is accepted, `dq_en_o` is low at once, and a read in flight is dropped.
- R10: After `sleep_i` falls, the first three rising edges with `sleep_i` low still accept no cycle. The fourth such edge accepts a cycle normally.
- R11: After reset, `dq_en_o` is low, `dq_o` is zero and the core is awake. Reset does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address from the sequencer |
| cyc_valid_i | input | 1 | Cycle valid and device selected |
| proc_start_i | input | 1 | Cycle started by the processor strobe (forced read) |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write qualifier, active low |
| be_ni | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| dq_o | output | 32 | Read data, zero when not driven |
| dq_en_o | output | 1 | Output drive enable |

## Verification
The bench targets the lane decode at its edges:
- A global write combined with every lane disabled: a wrong priority would drop the write.
- All lane enables high with the qualifier low: a wrong decode would write something.
- A strobe-started cycle carrying write enables: a core that does not force it to read would corrupt the array.

Each read-back exposes any lane that was written by mistake.

The bench also places accesses on each of the three edges after sleep falls and on the fourth. A counter that is off by one would accept one cycle too many or one too few.

Two further cases close the set:
- Output enable is toggled in the cycle a read returns, so a registered gate would show up one cycle late.
- A read follows a write to the same word directly, so a missing write-before-read ordering would return the old data.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned DATA_W   = LANES * LANE_W;
  localparam int unsigned WAKE_CYC = 3;

  typedef logic [LANES-1:0] lane_mask_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_pipe_pkg::*;
(
  input  logic       proc_start_i,
  input  logic       gw_ni,
  input  logic       bwe_ni,
  input  lane_mask_t be_ni,
  output lane_mask_t we_o,
  output logic       rd_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // global write wins over the qualified lane enables; strobe cycles never write
    assign we_o[g] = !proc_start_i && (!gw_ni || (!bwe_ni && !be_ni[g]));
  end
  assign rd_o = (we_o == '0);
endmodule

// File: rtl/sram_pwr_ctl.sv
module sram_pwr_ctl #(
  parameter int unsigned WAKE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic awake_o
);
  localparam int unsigned CNT_W = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0] wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wake_q <= '0;
    else if (sleep_i)           wake_q <= CNT_W'(WAKE_CYC);
    else if (wake_q != '0)      wake_q <= wake_q - 1'b1;
  end

  assign awake_o = !sleep_i && (wake_q == '0);
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  lane_mask_t        we_i,
  input  logic              rd_i,
  input  word_t             wdata_i,
  output word_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] dout_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (rd_i)    dout_q        <= mem_q[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = dout_q;
  end
endmodule

// File: rtl/sram_pipe_core.sv
module sram_pipe_core
  import sram_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cyc_valid_i,
  input  logic              proc_start_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [3:0]        be_ni,
  input  logic [31:0]       wdata_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [31:0]       dq_o,
  output logic              dq_en_o
);
  lane_mask_t        dec_we;
  logic              dec_rd;
  logic              awake;
  logic              accept;
  logic              rd_q;
  lane_mask_t        we_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             wdata_q;
  logic              dout_vld_q;
  word_t             rdata;

  sram_wr_decode i_dec (
    .proc_start_i(proc_start_i),
    .gw_ni       (gw_ni),
    .bwe_ni      (bwe_ni),
    .be_ni       (be_ni),
    .we_o        (dec_we),
    .rd_o        (dec_rd)
  );

  sram_pwr_ctl #(.WAKE_CYC(WAKE_CYC)) i_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_i),
    .awake_o(awake)
  );

  assign accept = cyc_valid_i && awake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= accept && dec_rd;
      we_q    <= accept ? dec_we : '0;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  sram_array #(.ADDR_W(ADDR_W)) i_arr (
    .clk_i  (clk_i),
    .addr_i (addr_q),
    .we_i   (we_q),
    .rd_i   (rd_q),
    .wdata_i(wdata_q),
    .rdata_o(rdata)
  );

  // read in flight is dropped if sleep arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_vld_q <= 1'b0;
    else         dout_vld_q <= rd_q && !sleep_i;
  end

  assign dq_en_o = dout_vld_q && !oe_ni && awake;
  assign dq_o    = dq_en_o ? rdata : '0;
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_valid_i,
  input logic proc_start_i,
  input logic gw_ni,
  input logic oe_ni,
  input logic sleep_i,
  input logic awake_i,
  input logic dq_en_o
);
  a_r7_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_en_o);

  a_r9_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_en_o);

  a_r8_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |-> ##2 !dq_en_o);

  a_r2_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && awake_i && !proc_start_i && !gw_ni) |-> ##2 !dq_en_o);

  a_r5_strobe_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && awake_i && proc_start_i)
      |-> ##2 (dq_en_o || oe_ni || sleep_i || !awake_i));

  a_r10_wake_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sleep_i) && $past(rst_ni))
      |-> !dq_en_o ##1 !dq_en_o ##1 !dq_en_o ##1 !dq_en_o);
endmodule

bind sram_pipe_core sram_pipe_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_valid_i (cyc_valid_i),
  .proc_start_i(proc_start_i),
  .gw_ni       (gw_ni),
  .oe_ni       (oe_ni),
  .sleep_i     (sleep_i),
  .awake_i     (awake),
  .dq_en_o     (dq_en_o)
);

// File: tb/test_sram_pipe_core.sv
`timescale 1ns/1ps
module test_sram_pipe_core;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cyc_valid_i = 1'b0, proc_start_i = 1'b0;
  logic          gw_ni = 1'b1, bwe_ni = 1'b1;
  logic [3:0]    be_ni = 4'hf;
  logic [31:0]   wdata_i = '0;
  logic          oe_ni = 1'b0, sleep_i = 1'b0;
  logic [31:0]   dq_o;
  logic          dq_en_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] rmem [DEPTH];
  bit          rknown [DEPTH];
  bit          pend_vld = 0, pend_known = 0, out_vld = 0, out_known = 0;
  logic [31:0] pend_data = '0, out_data = '0;
  int          wake = 0;

  sram_pipe_core #(.ADDR_W(AW)) i_sram_pipe_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .cyc_valid_i(cyc_valid_i),
    .proc_start_i(proc_start_i), .gw_ni(gw_ni), .bwe_ni(bwe_ni), .be_ni(be_ni),
    .wdata_i(wdata_i), .oe_ni(oe_ni), .sleep_i(sleep_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit ps, bit gw, bit bwe, logic [3:0] be, int a,
                     logic [31:0] d, bit oe, bit slp, string req);
    bit exp_en, awake_m, acc, rd;
    logic [3:0] we;
    @(negedge clk_i);
    cyc_valid_i = v; proc_start_i = ps; gw_ni = gw; bwe_ni = bwe; be_ni = be;
    addr_i = AW'(a); wdata_i = d; oe_ni = oe; sleep_i = slp;
    #1;
    exp_en = out_vld && !oe && !slp && (wake == 0);
    chk(dq_en_o === exp_en, req, "drive", 32'(dq_en_o), 32'(exp_en));
    if (exp_en && out_known) chk(dq_o === out_data, req, "data", dq_o, out_data);
    if (!exp_en) chk(dq_o === 32'h0, req, "idle data", dq_o, 32'h0);
    @(posedge clk_i);
    awake_m = !slp && (wake == 0);
    acc = v && awake_m;
    for (int k = 0; k < 4; k++) we[k] = !ps && (!gw || (!bwe && !be[k]));
    rd = (we == 4'h0);
    out_vld = pend_vld && !slp; out_data = pend_data; out_known = pend_known;
    pend_vld = acc && rd;
    if (acc && !rd) begin
      for (int k = 0; k < 4; k++) if (we[k]) rmem[a][k*8 +: 8] = d[k*8 +: 8];
      if (we == 4'hf) rknown[a] = 1;
    end
    if (acc && rd) begin pend_data = rmem[a]; pend_known = rknown[a]; end
    if (slp) wake = 3; else if (wake > 0) wake--;
  endtask

  task automatic wr(int a, logic [31:0] d, bit gw, bit bwe, logic [3:0] be, string req);
    cyc(1, 0, gw, bwe, be, a, d, 0, 0, req);
  endtask
  task automatic rd(int a, string req);
    cyc(1, 0, 1, 1, 4'hf, a, 32'hdead_beef, 0, 0, req);
  endtask
  task automatic idle(string req);
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) rknown[i] = 0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(dq_en_o === 1'b0, "R11", "reset drive", 32'(dq_en_o), 0);
    chk(dq_o === 32'h0, "R11", "reset data", dq_o, 0);
    rst_ni = 1'b1;
    idle("R11"); idle("R11");

    // R2: global write ignores lane controls
    wr(5, 32'hA1A2_A3A4, 0, 1, 4'hf, "R2");
    rd(5, "R6"); idle("R2"); idle("R2");
    wr(6, 32'h1111_2222, 0, 0, 4'h5, "R2");
    rd(6, "R2"); idle("R2"); idle("R2");

    // R3: per-lane writes
    wr(5, 32'hB1B2_B3B4, 1, 0, 4'b1010, "R3");
    rd(5, "R3"); idle("R3"); idle("R3");
    wr(5, 32'hC1C2_C3C4, 1, 0, 4'b0111, "R3");
    rd(5, "R3"); idle("R3"); idle("R3");

    // R4: qualifier high or all lanes off -> read, no write
    cyc(1, 0, 1, 1, 4'h0, 6, 32'hFFFF_FFFF, 0, 0, "R4");
    cyc(1, 0, 1, 0, 4'hf, 6, 32'hEEEE_EEEE, 0, 0, "R4");
    idle("R4"); idle("R4");
    rd(6, "R4"); idle("R4"); idle("R4");

    // R5: strobe cycle with global write is a read
    cyc(1, 1, 0, 0, 4'h0, 5, 32'h5555_5555, 0, 0, "R5");
    idle("R5"); idle("R5");
    rd(5, "R5"); idle("R5"); idle("R5");

    // R6: streaming reads, write then read same word
    wr(7, 32'h0707_0707, 0, 1, 4'hf, "R6");
    rd(7, "R6"); rd(5, "R6"); rd(6, "R6");
    wr(7, 32'h7070_7070, 0, 1, 4'hf, "R6");
    rd(7, "R6"); idle("R6"); idle("R6");

    // R7: oe high during returning data
    rd(5, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 1, 0, "R7");
    rd(6, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 1, 0, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 0, "R7");
    rd(6, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 0, "R7");

    // R8: deselected write must not land
    cyc(0, 0, 0, 0, 4'h0, 7, 32'h8888_8888, 0, 0, "R8");
    idle("R8"); idle("R8");
    rd(7, "R8"); idle("R8"); idle("R8");

    // R9/R10: sleep with read in flight, then wake-up window
    rd(5, "R9");
    cyc(1, 0, 0, 1, 4'hf, 5, 32'h9999_9999, 0, 1, "R9");
    cyc(1, 0, 0, 1, 4'hf, 6, 32'h9999_9999, 0, 1, "R9");
    cyc(1, 0, 0, 1, 4'hf, 10, 32'hA0A0_0001, 0, 0, "R10");
    cyc(1, 0, 0, 1, 4'hf, 11, 32'hA0A0_0002, 0, 0, "R10");
    cyc(1, 0, 0, 1, 4'hf, 12, 32'hA0A0_0003, 0, 0, "R10");
    cyc(1, 0, 0, 1, 4'hf, 13, 32'hA0A0_0004, 0, 0, "R10");
    rd(5, "R9"); rd(6, "R9"); rd(13, "R10");
    idle("R10"); idle("R10");
    // preload wake-window addresses, then retry sleep and check they stayed
    wr(10, 32'h1010_1010, 0, 1, 4'hf, "R10");
    wr(11, 32'h1111_1111, 0, 1, 4'hf, "R10");
    wr(12, 32'h1212_1212, 0, 1, 4'hf, "R10");
    cyc(0, 0, 1, 1, 4'hf, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 1, 4'hf, 10, 32'hBAD0_0001, 0, 0, "R10");
    cyc(1, 0, 0, 1, 4'hf, 11, 32'hBAD0_0002, 0, 0, "R10");
    cyc(1, 0, 0, 1, 4'hf, 12, 32'hBAD0_0003, 0, 0, "R10");
    rd(10, "R10"); rd(11, "R10"); rd(12, "R10");
    idle("R10"); idle("R10");

    // R1: address extremes
    wr(DEPTH - 1, 32'hFEED_0001, 0, 1, 4'hf, "R1");
    wr(0, 32'hFEED_0000, 0, 1, 4'hf, "R1");
    rd(DEPTH - 1, "R1"); rd(0, "R1");
    idle("R1"); idle("R1");

    // R11: contents survive reset
    @(negedge clk_i); rst_ni = 1'b0; cyc_valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    pend_vld = 0; out_vld = 0; wake = 0;
    rd(0, "R11"); idle("R11"); idle("R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule